// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Update

This block is the arithmetic and logic stage of a small accumulator-oriented processor core. The caller presents a first operand (the accumulator or a memory byte), a second operand (an immediate, register or memory byte it has already fetched), a 3-bit operation code and a valid strobe. In the same cycle the block returns the result and a write enable that does not depend on where the result goes. It also returns a mask that shows which flags the operation touches. The zero, auxiliary-carry and carry flags are held inside the block and update on the clock edge that ends a valid operation.

Subtract-with-borrow takes the stored carry flag as its borrow-in. Compare performs a plain subtraction with no borrow-in and only changes the flags. The three bitwise operations change only the zero flag. Codes outside the defined set are treated as no-operations.

Top module: `alu8_core`

## Requirements
- R1: With op_sel 3'b000 (subtract-with-borrow) and op_valid high, result equals opnd_a minus opnd_b minus flag_cy, modulo 256, and wr_en is high in the same cycle.
- R2: After a valid subtract-with-borrow, flag_cy is 1 exactly when the unsigned opnd_a is less than opnd_b plus the borrow-in used.
- R3: After a valid subtract or compare, flag_ac is 1 exactly when opnd_a[3:0] is less than opnd_b[3:0] plus the borrow-in used (the stored carry for subtract, 0 for compare).
- R4: After any operation that updates the zero flag, flag_z is 1 exactly when its 8-bit result is 0x00.
- R5: With op_sel 3'b100 (compare), wr_en stays low. The flags take the values for opnd_a minus opnd_b, and the stored carry has no effect on them.
- R6: op_sel 3'b001, 3'b010 and 3'b011 give AND, OR and XOR of the operands on result with wr_en high. Only flag_z changes; flag_cy and flag_ac keep their values.
- R7: op_sel codes 3'b101, 3'b110 and 3'b111 leave wr_en low and flag_upd at 3'b000, and all flags unchanged.
- R8: While op_valid is low, wr_en is low, flag_upd is 3'b000 and all flags hold.
- R9: A high rst at a clock edge clears all three flags, even when op_valid is high.
- R10: flag_upd reports the flags that will update, with bit 2 for zero, bit 1 for auxiliary carry and bit 0 for carry. It is 3'b111 for subtract and compare and 3'b100 for the bitwise operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 8 | First operand (minuend / destination value) |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Combinational result |
| wr_en | output | 1 | Write-back enable for the destination |
| flag_upd | output | 3 | Flags this operation updates {z, ac, cy} |
| flag_z | output | 1 | Stored zero flag |
| flag_ac | output | 1 | Stored auxiliary-carry flag |
| flag_cy | output | 1 | Stored carry / borrow flag |

## Verification
The hardest case to reach is proving that compare ignores a stored carry of 1 while subtract-with-borrow consumes it. The carry flag can only be set from the ports by an earlier borrowing operation. The stimulus therefore first runs a subtraction that borrows, then issues compare and subtract on operand pairs where a borrow-in of 1 would change the zero, nibble and carry outcomes. Bitwise operations are also placed right after borrowing subtractions, so that carry and auxiliary carry are both 1 when their hold is checked. Without that, a wrongly cleared flag would look the same as a held one.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

   localparam logic [2:0] OP_SBB = 3'b000;
   localparam logic [2:0] OP_AND = 3'b001;
   localparam logic [2:0] OP_OR  = 3'b010;
   localparam logic [2:0] OP_XOR = 3'b011;
   localparam logic [2:0] OP_CMP = 3'b100;

   typedef struct packed {
      logic z;
      logic ac;
      logic cy;
   } flags_t;

   localparam flags_t UPD_ALL  = '{z: 1'b1, ac: 1'b1, cy: 1'b1};
   localparam flags_t UPD_ZERO = '{z: 1'b1, ac: 1'b0, cy: 1'b0};
   localparam flags_t UPD_NONE = '{z: 1'b0, ac: 1'b0, cy: 1'b0};

endpackage

// File: rtl/alu8_sub.sv
`timescale 1ns/1ps
// Subtractor with borrow-in, borrow-out and intermediate nibble borrow.
module alu8_sub #(
   parameter int W      = 8,
   parameter int NIB    = 4,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         bin,
   output logic [W-1:0] diff,
   output logic         bout,
   output logic         nbout
);

   if (NIB < 1 || NIB >= W) begin : g_bad_nib
      $error("alu8_sub: NIB must lie in 1..W-1");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] brw;
      assign brw[0] = bin;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign diff[i]  = a[i] ^ b[i] ^ brw[i];
         assign brw[i+1] = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & brw[i]);
      end
      assign bout  = brw[W];
      assign nbout = brw[NIB];
   end else begin : g_behav
      logic [W:0]   full;
      logic [NIB:0] low;
      assign full  = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};
      assign low   = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, bin};
      assign diff  = full[W-1:0];
      assign bout  = full[W];
      assign nbout = low[NIB];
   end

endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
// Bitwise unit: sel 01 AND, 10 OR, 11 XOR, 00 zero.
module alu8_logic #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic [W-1:0] y
);

   if (W < 1) begin : g_bad_w
      $error("alu8_logic: W must be positive");
   end

   always_comb begin
      unique case (sel)
         2'b01:   y = a & b;
         2'b10:   y = a | b;
         2'b11:   y = a ^ b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/1ps
// Flag register with per-bit update enable.
module alu8_flags
   import alu8_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  flags_t upd,
   input  flags_t nxt,
   output flags_t q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= UPD_NONE;
      end else begin
         if (upd.z)  q.z  <= nxt.z;
         if (upd.ac) q.ac <= nxt.ac;
         if (upd.cy) q.cy <= nxt.cy;
      end
   end

endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W          = 8,
   parameter int NIB        = 4,
   parameter bit RIPPLE_SUB = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         op_valid,
   input  logic [2:0]   op_sel,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   output logic [W-1:0] result,
   output logic         wr_en,
   output logic [2:0]   flag_upd,
   output logic         flag_z,
   output logic         flag_ac,
   output logic         flag_cy
);

   localparam int MSB = W - 1;

   if (W < 2) begin : g_bad_w
      $error("alu8_core: W must be at least 2");
   end

   flags_t       flg_q;
   flags_t       flg_nxt;
   flags_t       upd;
   logic         borrow_in;
   logic [MSB:0] sub_diff;
   logic         sub_bout;
   logic         sub_nbout;
   logic [MSB:0] log_y;
   logic [MSB:0] res_c;
   logic         we_c;
   flags_t       upd_c;

   // Stored carry acts as borrow only for subtract-with-borrow.
   assign borrow_in = (op_sel == OP_SBB) & flg_q.cy;

   alu8_sub #(.W(W), .NIB(NIB), .RIPPLE(RIPPLE_SUB)) u_sub (
      .a     (opnd_a),
      .b     (opnd_b),
      .bin   (borrow_in),
      .diff  (sub_diff),
      .bout  (sub_bout),
      .nbout (sub_nbout)
   );

   alu8_logic #(.W(W)) u_logic (
      .a   (opnd_a),
      .b   (opnd_b),
      .sel (op_sel[1:0]),
      .y   (log_y)
   );

   always_comb begin
      res_c        = '0;
      we_c         = 1'b0;
      upd_c        = UPD_NONE;
      flg_nxt.ac   = sub_nbout;
      flg_nxt.cy   = sub_bout;
      unique case (op_sel)
         OP_SBB: begin
            res_c = sub_diff;
            we_c  = 1'b1;
            upd_c = UPD_ALL;
         end
         OP_AND, OP_OR, OP_XOR: begin
            res_c = log_y;
            we_c  = 1'b1;
            upd_c = UPD_ZERO;
         end
         OP_CMP: begin
            res_c = sub_diff;
            upd_c = UPD_ALL;
         end
         default: ;
      endcase
      flg_nxt.z = ~|res_c;
   end

   assign upd = op_valid ? upd_c : UPD_NONE;

   alu8_flags u_flags (
      .clk (clk),
      .rst (rst),
      .upd (upd),
      .nxt (flg_nxt),
      .q   (flg_q)
   );

   assign result   = res_c;
   assign wr_en    = op_valid & we_c;
   assign flag_upd = upd;
   assign flag_z   = flg_q.z;
   assign flag_ac  = flg_q.ac;
   assign flag_cy  = flg_q.cy;

endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk #(
   parameter int W   = 8,
   parameter int NIB = 4
) (
   input logic         clk,
   input logic         rst,
   input logic         op_valid,
   input logic [2:0]   op_sel,
   input logic [W-1:0] opnd_a,
   input logic [W-1:0] opnd_b,
   input logic [W-1:0] result,
   input logic         wr_en,
   input logic [2:0]   flag_upd,
   input logic         flag_z,
   input logic         flag_ac,
   input logic         flag_cy
);

   p_sbb_write_r1: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_sel == 3'b000) |-> wr_en);

   p_sbb_carry_r2: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_sel == 3'b000) |=>
      (flag_cy == ({1'b0, $past(opnd_a)} < ({1'b0, $past(opnd_b)} + {{W{1'b0}}, $past(flag_cy)}))));

   p_cmp_nibble_r3: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_sel == 3'b100) |=>
      (flag_ac == ($past(opnd_a[NIB-1:0]) < $past(opnd_b[NIB-1:0]))));

   p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
      (op_valid && flag_upd[2]) |=> (flag_z == ($past(result) == '0)));

   p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_sel == 3'b100) |-> !wr_en);

   p_logic_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_sel != 3'b000 && op_sel < 3'b100) |=> ($stable(flag_cy) && $stable(flag_ac)));

   p_bad_code_r7: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_sel > 3'b100) |=> ($stable(flag_z) && $stable(flag_ac) && $stable(flag_cy)));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> ($stable(flag_z) && $stable(flag_ac) && $stable(flag_cy)));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      !op_valid |-> (!wr_en && flag_upd == 3'b000));

   p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (!flag_z && !flag_ac && !flag_cy));

   p_logic_mask_r10: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_sel != 3'b000 && op_sel < 3'b100) |-> (flag_upd == 3'b100));

endmodule

bind alu8_core alu8_core_chk #(.W(W), .NIB(NIB)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .op_valid (op_valid),
   .op_sel   (op_sel),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .result   (result),
   .wr_en    (wr_en),
   .flag_upd (flag_upd),
   .flag_z   (flag_z),
   .flag_ac  (flag_ac),
   .flag_cy  (flag_cy)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       op_valid = 1'b0;
   logic [2:0] op_sel = 3'b000;
   logic [7:0] opnd_a = 8'h00;
   logic [7:0] opnd_b = 8'h00;
   logic [7:0] result;
   logic       wr_en;
   logic [2:0] flag_upd;
   logic       flag_z, flag_ac, flag_cy;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   typedef struct {
      bit         comb;
      bit         chk_res;
      logic [7:0] res;
      logic       we;
      logic [2:0] upd;
      logic       z, ac, cy;
      string      req;
   } exp_t;

   exp_t q[$];
   int m_z = 0, m_ac = 0, m_cy = 0;

   always #4 clk = ~clk;   // 125 MHz

   alu8_core u_dut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .wr_en(wr_en),
      .flag_upd(flag_upd), .flag_z(flag_z), .flag_ac(flag_ac), .flag_cy(flag_cy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Driver: applies one operation and pushes its expected outcome.
   task automatic do_op(input logic [2:0] op, input int a, input int b, input string req);
      exp_t e;
      int   bi, d;
      @(negedge clk);
      op_valid = 1'b1; op_sel = op; opnd_a = a[7:0]; opnd_b = b[7:0];
      e.comb = 1'b1; e.chk_res = 1'b1; e.req = req;
      e.we = 1'b0; e.upd = 3'b000; e.res = 8'h00;
      case (op)
         3'b000, 3'b100: begin
            bi    = (op == 3'b000) ? m_cy : 0;
            d     = a - b - bi;
            e.res = d[7:0];
            e.we  = (op == 3'b000);
            e.upd = 3'b111;
            e.chk_res = (op == 3'b000);
            m_cy  = (a < b + bi) ? 1 : 0;
            m_ac  = ((a % 16) < (b % 16) + bi) ? 1 : 0;
            m_z   = (e.res == 8'h00) ? 1 : 0;
         end
         3'b001, 3'b010, 3'b011: begin
            e.res = (op == 3'b001) ? (a[7:0] & b[7:0]) :
                    (op == 3'b010) ? (a[7:0] | b[7:0]) : (a[7:0] ^ b[7:0]);
            e.we  = 1'b1;
            e.upd = 3'b100;
            m_z   = (e.res == 8'h00) ? 1 : 0;
         end
         default: e.chk_res = 1'b0;
      endcase
      e.z = m_z[0]; e.ac = m_ac[0]; e.cy = m_cy[0];
      q.push_back(e);
   endtask

   task automatic do_idle(input int a, input string req);
      exp_t e;
      @(negedge clk);
      op_valid = 1'b0; op_sel = 3'b000; opnd_a = a[7:0]; opnd_b = 8'h01;
      e.comb = 1'b1; e.chk_res = 1'b0; e.res = 8'h00; e.we = 1'b0; e.upd = 3'b000;
      e.z = m_z[0]; e.ac = m_ac[0]; e.cy = m_cy[0]; e.req = req;
      q.push_back(e);
   endtask

   task automatic do_reset_with_op();
      exp_t e;
      @(negedge clk);
      rst = 1'b1; op_valid = 1'b1; op_sel = 3'b000; opnd_a = 8'h00; opnd_b = 8'h05;
      m_z = 0; m_ac = 0; m_cy = 0;
      e.comb = 1'b0; e.chk_res = 1'b0; e.res = 8'h00; e.we = 1'b0; e.upd = 3'b000;
      e.z = 1'b0; e.ac = 1'b0; e.cy = 1'b0; e.req = "R9";
      q.push_back(e);
      @(negedge clk);
      rst = 1'b0; op_valid = 1'b0;
   endtask

   // Monitor: compares combinational outputs before the edge, flags after it.
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.comb) begin
               if (e.chk_res)
                  check(result == e.res, e.req, "result", int'(result), int'(e.res));
               check(wr_en == e.we, e.req, "wr_en", int'(wr_en), int'(e.we));
               check(flag_upd == e.upd, "R10", "flag_upd", int'(flag_upd), int'(e.upd));
            end
            @(posedge clk);
            #1;
            check(flag_z == e.z, e.req, "flag_z (R4)", int'(flag_z), int'(e.z));
            check(flag_ac == e.ac, e.req, "flag_ac (R3)", int'(flag_ac), int'(e.ac));
            check(flag_cy == e.cy, e.req, "flag_cy (R2)", int'(flag_cy), int'(e.cy));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int lf;
      repeat (3) @(posedge clk);
      #1;
      // R9: reset state
      check({flag_z, flag_ac, flag_cy} == 3'b000, "R9", "flags after reset",
            int'({flag_z, flag_ac, flag_cy}), 0);
      @(negedge clk);
      rst = 1'b0;

      // R1 R4: exact zero difference
      do_op(3'b000, 8'h55, 8'h55, "R4");
      // R2 R3: full and nibble borrow from 0x00 - 0x01
      do_op(3'b000, 8'h00, 8'h01, "R2");
      // R1: stored carry consumed as borrow-in
      do_op(3'b000, 8'h00, 8'h00, "R1");
      do_op(3'b000, 8'h10, 8'h01, "R3");
      do_op(3'b000, 8'h80, 8'h7F, "R1");
      do_op(3'b000, 8'h05, 8'h05, "R1");
      // R5: set carry, then compare equal operands: borrow ignored
      do_op(3'b000, 8'h00, 8'h01, "R2");
      do_op(3'b100, 8'h42, 8'h42, "R5");
      do_op(3'b100, 8'h05, 8'h06, "R5");
      do_op(3'b100, 8'hF0, 8'h0F, "R5");
      // R6: bitwise ops with cy/ac both 1 beforehand
      do_op(3'b000, 8'h00, 8'h01, "R2");
      do_op(3'b001, 8'hF0, 8'h0F, "R6");
      do_op(3'b010, 8'h00, 8'h00, "R6");
      do_op(3'b010, 8'hA0, 8'h05, "R6");
      do_op(3'b011, 8'h3C, 8'h3C, "R6");
      do_op(3'b011, 8'hFF, 8'h0F, "R6");
      // R7: undefined codes
      do_op(3'b101, 8'h00, 8'hFF, "R7");
      do_op(3'b110, 8'h12, 8'h34, "R7");
      do_op(3'b111, 8'h00, 8'h00, "R7");
      // R8: idle with operands that would change flags
      do_idle(8'h00, "R8");
      do_idle(8'h33, "R8");
      // R9: reset wins over a valid operation
      do_reset_with_op();
      // sweep
      lf = 8'hA5;
      for (int i = 0; i < 64; i++) begin
         int a, b;
         lf = ((lf << 1) ^ ((lf & 8'h80) ? 8'h1D : 0)) & 8'hFF;
         a = lf;
         lf = ((lf << 1) ^ ((lf & 8'h80) ? 8'h1D : 0)) & 8'hFF;
         b = (i % 5 == 0) ? a : lf;
         do_op(i % 8, a, b, (i % 8 == 0) ? "R1" : (i % 8 == 4) ? "R5" : (i % 8 > 4) ? "R7" : "R6");
      end
      do_idle(8'h00, "R8");
      while (q.size() > 0) @(posedge clk);
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule